// File: doc/BRIEF.md
# Interleaved-Framebuffer Sprite Blitter

This block copies a solid rectangular sprite, stored as a packed run of bytes with no gap between rows, into a framebuffer whose pixel lines are interleaved. In that framebuffer, eight consecutive screen lines form one character row. Each of those lines lives in its own 2 KB block, so the next line of a character row starts 0x800 higher. The next character row starts 0x50 past the first line of the current one. A host issues one start command carrying a source address, a destination address, a width in bytes and a height in lines. The engine then moves every byte unchanged, one read followed by one write, through two simple request/ready memory ports.

The destination walks one byte at a time along a line. At the end of each line it goes back to a saved line-start register and moves that register to the next screen line. It adds 0x800 while it stays inside a character row. When it leaves the eighth line of a character row, it applies a single correction that brings it back to the first 2 KB block, one character row lower. There is no multiply and no fixed pitch. A one-cycle done pulse marks completion, and a malformed command gets a one-cycle error pulse instead.

Top module: `sprite_blit`

## Requirements
- R1: A start command whose width is 0 or above 63, or whose height is 0, raises err for exactly one cycle in the cycle after the command. It makes no read or write request and leaves busy low.
- R2: A start command that arrives while busy is high is ignored. The running copy continues with its original addresses and sizes, and no err is raised.
- R3: Source bytes are read at consecutive addresses from the source address, row after row with no padding. Each byte read is written unchanged.
- R4: Within one sprite row, each write address is one greater than the previous one, starting at the destination address on the first row.
- R5: When the current line start has bits [13:11] not equal to 7, the next row's first write address is the line start plus 0x800.
- R6: When the current line start has bits [13:11] equal to 7, the next row's first write address is the line start minus 0x37B0. This lands in the first 2 KB block, 0x50 beyond that character row's first line.
- R7: Each byte is read before it is written, and the next read request only follows the write handshake. A request holds its address and data until its ready is seen high at a clock edge.
- R8: done is high for exactly one cycle, in the cycle after the last write handshake. busy falls at the same time.
- R9: After reset, busy, done, err, rdReq and wrReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command strobe |
| srcAddr | input | 16 | Sprite source address |
| dstAddr | input | 16 | Framebuffer destination address |
| widthBytes | input | 8 | Sprite width in bytes |
| heightLines | input | 8 | Sprite height in lines |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejected-command pulse |
| rdReq | output | 1 | Read request |
| rdAddr | output | 16 | Read address |
| rdReady | input | 1 | Read accepted; rdData valid |
| rdData | input | 8 | Read data |
| wrReq | output | 1 | Write request |
| wrAddr | output | 16 | Write address |
| wrData | output | 8 | Write data |
| wrReady | input | 1 | Write accepted |

## Verification
Two events can share one clock edge: the final write handshake that ends a copy, and a new start command. The first retires the copy and fires done. The second must be ignored, because the engine is still busy at that edge. The bench provokes this by presenting start commands during copies under randomly stalled ready signals, so some of them fall on the closing write edge. A cycle-accurate reference model decides from its own busy state whether each command is accepted. It then compares every handshake address, every data byte, and the busy, done and err outputs on every clock.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef struct packed {
    logic load;
    logic capture;
    logic stepCol;
    logic stepRow;
  } blitStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } blitStateT;
endpackage

// File: rtl/blit_dpath.sv
module blit_dpath
  import blit_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8,
  parameter int LINE_STEP     = 'h800,
  parameter int LINES_PER_ROW = 8,
  parameter int ROW_STEP      = 'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  blitStrobeT        strb,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  widthIn,
  input  logic [CNT_W-1:0]  heightIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastCol,
  output logic              lastRow
);
  localparam int LINE_LSB  = $clog2(LINE_STEP);
  localparam int LINE_BITS = $clog2(LINES_PER_ROW);
  localparam int WRAP_SUB  = LINE_STEP * (LINES_PER_ROW - 1) - ROW_STEP;
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(LINE_STEP);
  localparam logic [ADDR_W-1:0] WRAP_A = ADDR_W'(WRAP_SUB);
  localparam logic [LINE_BITS-1:0] LAST_LINE = LINE_BITS'(LINES_PER_ROW - 1);

  logic [ADDR_W-1:0] lineStart, lineNext;
  logic [CNT_W-1:0]  widthReg, colCnt, rowCnt;
  logic [DATA_W-1:0] dataReg;
  logic              atRowEnd;

  assign atRowEnd = lineStart[LINE_LSB +: LINE_BITS] == LAST_LINE;
  assign lineNext = atRowEnd ? (lineStart - WRAP_A) : (lineStart + STEP_A);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr    <= '0;
      dstPtr    <= '0;
      lineStart <= '0;
      widthReg  <= '0;
      colCnt    <= '0;
      rowCnt    <= '0;
      dataReg   <= '0;
    end else begin
      if (strb.load) begin
        srcPtr    <= srcIn;
        dstPtr    <= dstIn;
        lineStart <= dstIn;
        widthReg  <= widthIn;
        colCnt    <= widthIn;
        rowCnt    <= heightIn;
      end
      if (strb.capture) dataReg <= rdData;
      if (strb.stepCol) begin
        srcPtr <= srcPtr + 1'b1;
        dstPtr <= dstPtr + 1'b1;
        colCnt <= colCnt - 1'b1;
      end
      if (strb.stepRow) begin
        srcPtr    <= srcPtr + 1'b1;
        lineStart <= lineNext;
        dstPtr    <= lineNext;
        colCnt    <= widthReg;
        rowCnt    <= rowCnt - 1'b1;
      end
    end
  end

  assign wrData  = dataReg;
  assign lastCol = colCnt == CNT_W'(1);
  assign lastRow = rowCnt == CNT_W'(1);

  AST_SRC_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepCol || strb.stepRow) |=> (srcPtr - $past(srcPtr)) == ADDR_W'(1)); // R3
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepCol |=> (dstPtr - $past(dstPtr)) == ADDR_W'(1) && $stable(lineStart)); // R4
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepRow && !atRowEnd) |=> lineStart[LINE_LSB +: LINE_BITS] ==
      $past(lineStart[LINE_LSB +: LINE_BITS]) + 1'b1 && dstPtr == lineStart); // R5
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepRow && atRowEnd) |=> lineStart[LINE_LSB +: LINE_BITS] == '0 &&
      lineStart[LINE_LSB-1:0] == $past(lineStart[LINE_LSB-1:0]) + LINE_LSB'(ROW_STEP)); // R6
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_WIDTH = 63
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] widthIn,
  input  logic [CNT_W-1:0] heightIn,
  input  logic             rdReady,
  input  logic             wrReady,
  input  logic             lastCol,
  input  logic             lastRow,
  output blitStrobeT       strb,
  output logic             rdReq,
  output logic             wrReq,
  output logic             busy,
  output logic             done,
  output logic             err
);
  blitStateT state, stateNext;
  logic      startOk, finish;

  assign startOk = (widthIn != '0) && (widthIn <= CNT_W'(MAX_WIDTH)) && (heightIn != '0);
  assign finish  = (state == ST_WRITE) && wrReady && lastCol && lastRow;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (startValid && startOk) begin
        strb.load = 1'b1;
        stateNext = ST_READ;
      end
      ST_READ: if (rdReady) begin
        strb.capture = 1'b1;
        stateNext    = ST_WRITE;
      end
      ST_WRITE: if (wrReady) begin
        if (!lastCol)      strb.stepCol = 1'b1;
        else if (!lastRow) strb.stepRow = 1'b1;
        stateNext = (lastCol && lastRow) ? ST_IDLE : ST_READ;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finish;
      err   <= (state == ST_IDLE) && startValid && !startOk;
    end
  end

  assign rdReq = state == ST_READ;
  assign wrReq = state == ST_WRITE;
  assign busy  = state != ST_IDLE;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !rdReq && !wrReq && !busy); // R1
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startValid && !(wrReq && wrReady)) |=> busy && !err); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdReady) |=> rdReq); // R7
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdReady) |=> wrReq && !rdReq); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !rdReq && !wrReq); // R8
endmodule

// File: rtl/sprite_blit.sv
module sprite_blit
  import blit_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8,
  parameter int MAX_WIDTH     = 63,
  parameter int LINE_STEP     = 'h800,
  parameter int LINES_PER_ROW = 8,
  parameter int ROW_STEP      = 'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [CNT_W-1:0]  widthBytes,
  input  logic [CNT_W-1:0]  heightLines,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrReady
);
  blitStrobeT strb;
  logic       lastCol, lastRow;

  blit_ctrl #(.CNT_W(CNT_W), .MAX_WIDTH(MAX_WIDTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .widthIn(widthBytes), .heightIn(heightLines),
    .rdReady(rdReady), .wrReady(wrReady),
    .lastCol(lastCol), .lastRow(lastRow),
    .strb(strb), .rdReq(rdReq), .wrReq(wrReq),
    .busy(busy), .done(done), .err(err)
  );

  blit_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .LINE_STEP(LINE_STEP), .LINES_PER_ROW(LINES_PER_ROW), .ROW_STEP(ROW_STEP)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcIn(srcAddr), .dstIn(dstAddr),
    .widthIn(widthBytes), .heightIn(heightLines),
    .rdData(rdData),
    .srcPtr(rdAddr), .dstPtr(wrAddr), .wrData(wrData),
    .lastCol(lastCol), .lastRow(lastRow)
  );
endmodule

// File: tb/test_sprite_blit.sv
module test_sprite_blit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [15:0] srcAddr = '0, dstAddr = '0;
  logic [7:0]  widthBytes = '0, heightLines = '0;
  logic        busy, done, err, rdReq, wrReq;
  logic [15:0] rdAddr, wrAddr;
  logic [7:0]  rdData, wrData;
  logic        rdReady = 1'b0, wrReady = 1'b0;

  int checks = 0;
  int errors = 0;
  bit stallMode = 1'b0;
  bit monOn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [15:0] rdQ[$];
  logic [15:0] wrQ[$];
  logic [7:0]  dataQ[$];
  bit mBusy = 1'b0, doneDue = 1'b0, errDue = 1'b0;

  always #2 clk = ~clk;

  sprite_blit i_sprite_blit (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .widthBytes(widthBytes), .heightLines(heightLines),
    .busy(busy), .done(done), .err(err),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd5) ^ 8'h3C;
  endfunction

  assign rdData = memFn(rdAddr);

  function automatic logic [15:0] lineAddr(input logic [15:0] d, input int r);
    int off, y0, x0, y;
    off = int'(d[13:0]);
    y0  = ((off >> 11) & 7) + 8 * ((off & 'h7FF) / 80);
    x0  = (off & 'h7FF) % 80;
    y   = y0 + r;
    return {d[15:14], 14'd0} + 16'((y % 8) * 'h800 + (y / 8) * 80 + x0);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit wasBusy;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdReady <= stallMode ? lfsr[0] : 1'b1;
    wrReady <= stallMode ? lfsr[5] : 1'b1;
    #1;
    if (monOn) begin
      wasBusy = mBusy;
      check(busy == mBusy, "R2/R8 busy", busy, mBusy);
      check(done == doneDue, "R8 done", done, doneDue);
      check(err == errDue, "R1 err", err, errDue);
      doneDue = 1'b0;
      errDue  = 1'b0;
      if (!mBusy) check(!rdReq && !wrReq, "R1 idle access", {rdReq, wrReq}, 0);
      check(!(rdReq && wrReq), "R7 overlap", {rdReq, wrReq}, 0);
      if (rdReq && rdReady) begin
        if (rdQ.size() == 0) check(1'b0, "R3 extra read", rdAddr, 0);
        else begin
          logic [15:0] e;
          e = rdQ.pop_front();
          check(rdAddr == e, "R3 read addr", rdAddr, e);
        end
      end
      if (wrReq && wrReady) begin
        if (wrQ.size() == 0) check(1'b0, "R4 extra write", wrAddr, 0);
        else begin
          logic [15:0] ea;
          logic [7:0]  ed;
          ea = wrQ.pop_front();
          ed = dataQ.pop_front();
          check(wrAddr == ea, "R4/R5/R6 write addr", wrAddr, ea);
          check(wrData == ed, "R3 write data", wrData, ed);
          if (wrQ.size() == 0) begin
            doneDue = 1'b1;
            mBusy   = 1'b0;
          end
        end
      end
      if (startValid && !wasBusy) begin
        if (widthBytes == 0 || widthBytes > 63 || heightLines == 0) errDue = 1'b1;
        else begin
          for (int r = 0; r < int'(heightLines); r++)
            for (int c = 0; c < int'(widthBytes); c++) begin
              logic [15:0] s;
              s = srcAddr + 16'(r * int'(widthBytes) + c);
              rdQ.push_back(s);
              dataQ.push_back(memFn(s));
              wrQ.push_back(lineAddr(dstAddr, r) + 16'(c));
            end
          mBusy = 1'b1;
        end
      end
    end
  end

  task automatic issue(input logic [15:0] s, input logic [15:0] d,
                       input logic [7:0] w, input logic [7:0] h);
    @(negedge clk);
    srcAddr = s; dstAddr = d; widthBytes = w; heightLines = h;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mBusy || doneDue) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !err && !rdReq && !wrReq, "R9 reset", {busy, done, err, rdReq, wrReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    // R3 R4 R5: small sprite, fast memory
    issue(16'h1000, 16'hC000, 8'd2, 8'd3); waitIdle();
    // R6: crosses a character row boundary
    stallMode = 1'b1;
    issue(16'h2000, 16'hC000, 8'd3, 8'd10); waitIdle();
    // R6: starts on the eighth line, width 63
    issue(16'h3000, 16'hF8A0, 8'd63, 8'd2); waitIdle();
    // minimum sprite
    stallMode = 1'b0;
    issue(16'hFFFF, 16'hC7CF, 8'd1, 8'd1); waitIdle();
    // R1: malformed commands
    issue(16'h1111, 16'hC000, 8'd0, 8'd4); waitIdle();
    issue(16'h1111, 16'hC000, 8'd64, 8'd4); waitIdle();
    issue(16'h1111, 16'hC000, 8'd4, 8'd0); waitIdle();
    // R2: commands while busy, including near the final write
    stallMode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      issue(16'h4000 + 16'(k * 64), 16'hC0F0 + 16'(k), 8'd4, 8'd9);
      repeat (5 + k) @(negedge clk);
      issue(16'h9000, 16'hD000, 8'd7, 8'd7);
      issue(16'h9100, 16'hD100, 8'd0, 8'd0);
      for (int j = 0; j < 200 && mBusy; j++) begin
        issue(16'hA000, 16'hE000, 8'd5, 8'd5);
      end
      waitIdle();
    end
    check(rdQ.size() == 0 && wrQ.size() == 0, "R3 leftover", rdQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule